// File: doc/BRIEF.md
# Color Key Overlay Controller

The block watches the byte stream that leaves the pixel pipeline toward the DAC. While display-enable is high it samples bytes at a programmable cadence and compares each sampled byte, or a window of the most recent bytes, against a programmed key color. When the sampled color equals the key, a match level is raised. After a programmable delay, a pair of tristate-control outputs is raised as well. External overlay video uses these outputs to take over the pixel bus and the pixel clock for as long as the key color is present.

Software sets the block up through a small byte-wide register port. An 8-bit control word selects the enable, the sampling interval, the delay and its unit, the output clock edge and suppression of the tristate outputs. Further registers hold the key bytes and a flag that selects wide (multi-byte) compare. All logic runs on the pixel clock. The outputs can be launched from the rising edge or from the falling edge of that clock.

Top module: `colorkey_overlay`

## Requirements
- R1: While reset is high and on the first cycles after it, all registers read as zero and the outputs `key_match`, `ovl_pix_tri` and `ovl_clk_tri` are low.
- R2: A write with `cfg_we` high is captured on the rising edge and governs the following cycles. Address 0 is the control word: bit 0 enable, bit 1 rising-edge output, bits 3:2 sample interval code, bits 5:4 delay count, bit 6 keep outputs driven, bit 7 delay counted in bytes. Addresses 1, 2 and 3 hold key bytes 0, 1 and 2. Bit 0 at address 4 selects wide compare.
- R3: The first byte of every period in which display-enable is high is sampled. After it, one byte in every (code+1) bytes is sampled, counted from that first byte.
- R4: In narrow compare, a sample matches when the current byte equals key byte 0.
- R5: In wide compare, a sample matches when the concatenation {byte two cycles earlier, byte one cycle earlier, current byte} equals {key byte 2, key byte 1, key byte 0}.
- R6: The match level takes the result of each sample one cycle after the sampling edge and holds it until the next sample. It is cleared while display-enable is low or the enable bit is clear.
- R7: The tristate level is the match level delayed by D cycles when the byte-unit bit is set, or by D×(code+1) cycles when it is clear, where D is the delay count. It asserts and deasserts with the same delay, and D=0 gives no delay.
- R8: The tristate outputs stay low when the keep-driven bit is set or the enable bit is clear. Both tristate outputs always carry the same value.
- R9: With the rising-edge bit set, every output changes just after the rising pixel-clock edge. With it clear, every output changes at the following falling edge and carries the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_en | input | 1 | Display-enable from the timing generator |
| pix | input | 8 | Outgoing pixel byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| key_match | output | 1 | Key color match level |
| ovl_pix_tri | output | 1 | Tristate request for the pixel bus |
| ovl_clk_tri | output | 1 | Tristate request for the pixel clock output |

## Verification
The assertions take for granted that reset is held for at least two clock edges, so that every `$past` and `$rose` term sees a defined value. They also assume that the sample interval code does not change while display-enable is high, because the phase counter only wraps cleanly against a steady code. The stimulus writes every register only in blanking, with display-enable low. It holds reset for five edges. It drives inputs between the falling edge and the next rising edge, so the falling-edge stage always captures settled values.

// File: rtl/ck_pkg.sv
`timescale 1ns/1ps
package ck_pkg;

    localparam int IVL_W   = 2;
    localparam int DLY_W   = 2;
    localparam int MAX_IVL = (1 << IVL_W);          // bytes per slowest sample period
    localparam int MAX_DLY = (1 << DLY_W) - 1;      // largest delay count
    localparam int MAX_TAP = MAX_DLY * MAX_IVL;     // deepest delay in cycles
    localparam int TAP_W   = $clog2(MAX_TAP + 1);

    // Control word, packed so that bit 0 is the enable.
    typedef struct packed {
        logic             dly_bytes;  // bit 7
        logic             keep_drv;   // bit 6
        logic [DLY_W-1:0] dly;        // bits 5:4
        logic [IVL_W-1:0] ivl;        // bits 3:2
        logic             rise;       // bit 1
        logic             en;         // bit 0
    } ck_ctrl_t;

    typedef struct packed {
        logic tri_lvl;
        logic match;
    } ck_out_t;

    // Delay in pixel-clock cycles selected by the control word.
    function automatic logic [TAP_W-1:0] tap_len(ck_ctrl_t c);
        logic [TAP_W-1:0] d;
        logic [TAP_W-1:0] span;
        d    = TAP_W'(c.dly);
        span = TAP_W'(c.ivl) + TAP_W'(1);
        return c.dly_bytes ? d : TAP_W'(d * span);
    endfunction

endpackage

// File: rtl/ck_regs.sv
`timescale 1ns/1ps
module ck_regs
    import ck_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int KEY_BYTES = 3,
    parameter int ADDR_W    = 3,
    localparam int KEY_W    = BYTE_W * KEY_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output ck_ctrl_t          ctrl_q,
    output logic [KEY_W-1:0]  key_q,
    output logic              wide_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            key_q  <= '0;
            wide_q <= 1'b0;
        end else if (we) begin
            if (addr == '0)
                ctrl_q <= ck_ctrl_t'(wdata[$bits(ck_ctrl_t)-1:0]);
            for (int i = 0; i < KEY_BYTES; i++) begin
                if (addr == ADDR_W'(i + 1))
                    key_q[i*BYTE_W +: BYTE_W] <= wdata;
            end
            if (addr == ADDR_W'(KEY_BYTES + 1))
                wide_q <= wdata[0];
        end
    end

endmodule

// File: rtl/ck_sampler.sv
`timescale 1ns/1ps
module ck_sampler
    import ck_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int KEY_BYTES = 3,
    localparam int KEY_W    = BYTE_W * KEY_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [IVL_W-1:0]  ivl,
    input  logic              wide,
    input  logic [KEY_W-1:0]  key,
    input  logic              disp_en,
    input  logic [BYTE_W-1:0] pix,
    output logic              match_hold,
    output logic              sample_now
);

    logic             de_q;
    logic [IVL_W-1:0] phase_q;
    logic             de_rise;
    logic             eq_narrow;
    logic             eq_wide;
    logic             hit;

    assign de_rise    = disp_en & ~de_q;
    assign sample_now = disp_en & (de_rise | (phase_q == ivl));
    assign eq_narrow  = (pix == key[BYTE_W-1:0]);
    assign hit        = wide ? eq_wide : eq_narrow;

    // Window of recent bytes for the wide compare.
    if (KEY_BYTES > 1) begin : g_window
        localparam int HW = KEY_W - BYTE_W;
        logic [HW-1:0] hist_q;
        always_ff @(posedge clk) begin
            if (rst) hist_q <= '0;
            else     hist_q <= HW'({hist_q, pix});
        end
        assign eq_wide = ({hist_q, pix} == key);
    end else begin : g_single
        assign eq_wide = eq_narrow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            de_q       <= 1'b0;
            phase_q    <= '0;
            match_hold <= 1'b0;
        end else begin
            de_q <= disp_en;
            if (sample_now)
                phase_q <= '0;
            else if (disp_en)
                phase_q <= phase_q + 1'b1;
            if (!en || !disp_en)
                match_hold <= 1'b0;
            else if (sample_now)
                match_hold <= hit;
        end
    end

    a_r3_first_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_en) |-> sample_now);
    a_r3_only_in_display: assert property (@(posedge clk) disable iff (rst)
        sample_now |-> disp_en);
    a_r6_clear_outside: assert property (@(posedge clk) disable iff (rst)
        (!disp_en || !en) |=> !match_hold);
    a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
        (disp_en && en && !sample_now) |=> $stable(match_hold));

endmodule

// File: rtl/ck_delay.sv
`timescale 1ns/1ps
module ck_delay #(
    parameter int DEPTH = 12,
    localparam int TW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          din,
    input  logic [TW-1:0] tap,
    output logic          dout
);

    logic [DEPTH-1:0] line_q;   // line_q[k] is din from k+1 cycles ago

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= {line_q[DEPTH-2:0], din};
    end

    always_comb begin
        if (tap == '0) dout = din;
        else           dout = line_q[tap - 1'b1];
    end

    a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (tap == TW'(1) && $past(tap) == TW'(1)) |-> dout == $past(din));
    a_r7_two_cycle: assert property (@(posedge clk) disable iff (rst)
        (tap == TW'(2) && $stable(tap)) |=> dout == $past(din, 2));

endmodule

// File: rtl/ck_edge_out.sv
`timescale 1ns/1ps
module ck_edge_out #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rise_sel,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] fall_q;

    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= d;
    end

    assign q = rise_sel ? d : fall_q;

    // At each rising edge the falling-edge copy still shows the value
    // launched on the previous rising edge.
    a_r9_fall_copy: assert property (@(posedge clk) disable iff (rst)
        !rise_sel |-> q == d);

endmodule

// File: rtl/colorkey_overlay.sv
`timescale 1ns/1ps
module colorkey_overlay
    import ck_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int KEY_BYTES = 3,
    localparam int KEY_W    = BYTE_W * KEY_BYTES,
    localparam int ADDR_W   = $clog2(KEY_BYTES + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_en,
    input  logic [BYTE_W-1:0] pix,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic              key_match,
    output logic              ovl_pix_tri,
    output logic              ovl_clk_tri
);

    ck_ctrl_t         ctrl_q;
    logic [KEY_W-1:0] key_q;
    logic             wide_q;
    logic             match_hold;
    logic             sample_now;
    logic             tri_dly;
    ck_out_t          pos_out;
    ck_out_t          edge_out;

    ck_regs #(.BYTE_W(BYTE_W), .KEY_BYTES(KEY_BYTES), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .ctrl_q (ctrl_q),
        .key_q  (key_q),
        .wide_q (wide_q)
    );

    ck_sampler #(.BYTE_W(BYTE_W), .KEY_BYTES(KEY_BYTES)) u_sampler (
        .clk        (clk),
        .rst        (rst),
        .en         (ctrl_q.en),
        .ivl        (ctrl_q.ivl),
        .wide       (wide_q),
        .key        (key_q),
        .disp_en    (disp_en),
        .pix        (pix),
        .match_hold (match_hold),
        .sample_now (sample_now)
    );

    ck_delay #(.DEPTH(MAX_TAP)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .din  (match_hold),
        .tap  (tap_len(ctrl_q)),
        .dout (tri_dly)
    );

    always_comb begin
        pos_out.match   = match_hold;
        pos_out.tri_lvl = tri_dly & ctrl_q.en & ~ctrl_q.keep_drv;
    end

    ck_edge_out #(.W($bits(ck_out_t))) u_edge (
        .clk      (clk),
        .rst      (rst),
        .rise_sel (ctrl_q.rise),
        .d        (pos_out),
        .q        (edge_out)
    );

    assign key_match   = edge_out.match;
    assign ovl_pix_tri = edge_out.tri_lvl;
    assign ovl_clk_tri = edge_out.tri_lvl;

    a_r8_keep_driven: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.keep_drv && $stable(ctrl_q) && ctrl_q.rise) |-> !ovl_pix_tri);
    a_r8_pair_equal: assert property (@(posedge clk) disable iff (rst)
        ovl_pix_tri == ovl_clk_tri);

endmodule

// File: tb/colorkey_overlay_tb_top.sv
`timescale 1ns/1ps
module colorkey_overlay_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       disp_en = 1'b0;
    logic [7:0] pix = 8'h00;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = 3'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       key_match, ovl_pix_tri, ovl_clk_tri;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    colorkey_overlay dut_i (
        .clk(clk), .rst(rst), .disp_en(disp_en), .pix(pix),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .key_match(key_match), .ovl_pix_tri(ovl_pix_tri), .ovl_clk_tri(ovl_clk_tri)
    );

    // Reference state
    logic [7:0]  m_ctl;
    logic [23:0] m_key;
    logic        m_wide;
    logic        m_de_prev;
    int          m_idx;
    logic [7:0]  m_b1, m_b2;
    logic        m_hold;
    bit          m_hist[$];
    logic        exp_m, exp_t, prev_m, prev_t;

    task automatic check(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctl = 8'h00; m_key = 24'h0; m_wide = 1'b0; m_de_prev = 1'b0;
        m_idx = 0; m_b1 = 8'h00; m_b2 = 8'h00; m_hold = 1'b0;
        m_hist = {};
        for (int i = 0; i < 16; i++) m_hist.push_front(1'b0);
        exp_m = 1'b0; exp_t = 1'b0; prev_m = 1'b0; prev_t = 1'b0;
    endtask

    task automatic tick();
        int  iv, n;
        bit  smp, eq;
        string tm, tt;
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            iv = int'(m_ctl[3:2]);
            if (disp_en && !m_de_prev) m_idx = 0;
            smp = disp_en && ((m_idx % (iv + 1)) == 0);
            eq  = m_wide ? ({m_b2, m_b1, pix} == m_key) : (pix == m_key[7:0]);
            if (!m_ctl[0] || !disp_en) m_hold = 1'b0;
            else if (smp)              m_hold = eq;
            if (disp_en) m_idx++;
            m_b2 = m_b1; m_b1 = pix; m_de_prev = disp_en;
            m_hist.push_front(m_hold);
            void'(m_hist.pop_back());
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_ctl = cfg_wdata;
                    3'd1: m_key[7:0]   = cfg_wdata;
                    3'd2: m_key[15:8]  = cfg_wdata;
                    3'd3: m_key[23:16] = cfg_wdata;
                    3'd4: m_wide = cfg_wdata[0];
                    default: ;
                endcase
            end
            n = m_ctl[7] ? int'(m_ctl[5:4]) : int'(m_ctl[5:4]) * (int'(m_ctl[3:2]) + 1);
            exp_m = m_hold;
            exp_t = m_ctl[0] && !m_ctl[6] && m_hist[n];
        end
        tm = rst ? "R1" : "R2/R3/R4/R5/R6";
        tt = rst ? "R1" : "R7/R8";
        #1;
        // R9: rising-edge mode shows the new value now, falling mode the old one
        check("R9", "key_match early", key_match, m_ctl[1] ? exp_m : prev_m);
        check("R9", "ovl_pix_tri early", ovl_pix_tri, m_ctl[1] ? exp_t : prev_t);
        #2;
        check(tm, "key_match", key_match, exp_m);
        check(tt, "ovl_pix_tri", ovl_pix_tri, exp_t);
        check("R8", "ovl_clk_tri", ovl_clk_tri, exp_t);
        prev_m = exp_m; prev_t = exp_t;
    endtask

    // R2: register writes, issued in blanking
    task automatic wr(logic [2:0] a, logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    function automatic logic [7:0] pgen(int k, int kind);
        case (kind)
            0: return (k % 3 == 0) ? m_key[7:0] : 8'(k);
            1: return ((k / 4) % 2 == 1) ? m_key[7:0] : 8'(k + 1);
            2: begin
                case (k % 6)
                    0: return m_key[23:16];
                    1: return m_key[15:8];
                    2: return m_key[7:0];
                    default: return 8'(k);
                endcase
            end
            default: return ((k / 7) % 2 == 0) ? m_key[7:0] : 8'(k + 3);
        endcase
    endfunction

    task automatic line(int len, int kind);
        for (int k = 0; k < len; k++) begin
            disp_en = 1'b1;
            pix = pgen(k, kind);
            tick();
        end
        for (int k = 0; k < 16; k++) begin
            disp_en = 1'b0;
            pix = m_key[7:0];   // key color in blanking must not match (R6)
            tick();
        end
    endtask

    task automatic scenario(logic [7:0] ctl, logic wide);
        wr(3'd0, ctl);
        wr(3'd4, {7'd0, wide});
        for (int kind = 0; kind < 4; kind++) line(40, kind);
    endtask

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #3;
        for (int i = 0; i < 3; i++) tick();   // R1 reset state
        rst = 1'b0;
        tick();
        wr(3'd1, 8'hA5);
        wr(3'd2, 8'h5A);
        wr(3'd3, 8'h3C);
        scenario(8'h03, 1'b0);   // every byte, no delay, rising edge
        scenario(8'h29, 1'b0);   // every third byte, 2 intervals, falling edge
        scenario(8'hBF, 1'b0);   // every fourth byte, 3 bytes, rising edge
        scenario(8'h15, 1'b1);   // wide compare, every second byte, 1 interval
        scenario(8'h53, 1'b0);   // keep outputs driven (R8)
        scenario(8'h02, 1'b0);   // function disabled (R6, R8)
        scenario(8'h3D, 1'b0);   // longest delay, falling edge (R7)
        scenario(8'h1B, 1'b1);   // wide, every third byte, 1 interval, rising
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule